// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a page-organised serial flash over a four-wire serial link: chip select, serial clock, serial data in (to the flash) and serial data out (from the flash). A host asks for one of three operations: read bytes from a main-memory page, write bytes into the device's buffer, or program the buffer into a main-memory page. With the request it supplies a page number, a byte or buffer column, a byte count and, for writes, the data bytes. The block then builds the command frame itself, one bit per serial clock cycle.

Each operation has its own frame shape. The opcode comes first. Address fields and runs of zero filler bits follow in an order that depends on the operation, and then the data bytes come last. A bit counter and a byte counter track the frame. Each time a segment ends on a falling clock edge, the block picks the next segment with a non-zero length, or ends the frame. Read bytes are handed to the host one at a time. Write bytes are taken from the host one at a time, each with its own strobe.

Top module: `sflash_cmd_seq`

## Requirements
- R1: While reset is held and right after it, `cs_n` is 1, and `sck`, `si`, `busy`, `done`, `rd_valid` and `wr_ready` are 0.
- R2: `cmd_op` selects the operation: 0 is page read with opcode 0xA1, 1 is buffer write with opcode 0xB2, and 2 is program with opcode 0xC3. A start with `cmd_op` equal to 3 is ignored: `cs_n` stays high and `busy` stays low.
- R3: A read frame is the 8-bit opcode, then the 12-bit page, then the 10-bit column, then 32 zero bits, for 62 bits in all. It is followed by `cmd_len` bytes that are sampled from `so` on rising `sck` edges, MSB first. Each byte is presented on `rd_data` with a single-cycle `rd_valid`.
- R4: A buffer-write frame is the 8-bit opcode, then 14 zero bits, then the 10-bit column, for 32 bits in all. It is followed by `cmd_len` bytes taken from `wr_data`, MSB first. A one-cycle `wr_ready` pulse follows each byte taken, and the host then presents the next byte.
- R5: A program frame is the 8-bit opcode, then the 12-bit page, then 10 zero bits, for 30 bits in all. It carries no data, whatever `cmd_len` is, and never pulses `wr_ready`.
- R6: One bit is sent for each `sck` cycle, and each cycle lasts 2*CLK_DIV system clocks. `si` changes only on falling `sck` edges, except when the first opcode bit is loaded at start.
- R7: `busy` rises in the cycle after an accepted start. `cs_n` is low exactly while `busy` is high. `done` is a one-cycle pulse in the cycle where `cs_n` returns high.
- R8: A start pulse while `busy` is high is ignored and does not change the frame in progress.
- R9: A read with `cmd_len` equal to 0 sends only the 62-bit header and gives no `rd_valid`.
- R10: `sck` stays low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted when idle |
| cmd_op | input | 2 | Operation select (0 read, 1 buffer write, 2 program) |
| cmd_page | input | 12 | Main-memory page number |
| cmd_col | input | 10 | Byte column or buffer column |
| cmd_len | input | 10 | Number of data bytes |
| wr_data | input | 8 | Write byte, held until `wr_ready` |
| wr_ready | output | 1 | Pulse: current write byte has been taken |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse at the end of an operation |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock to the flash |
| si | output | 1 | Serial data to the flash |
| so | input | 1 | Serial data from the flash |

## Verification
A bit-level flash model records every bit seen on `si` at rising clock edges and returns page- and column-dependent bytes on `so`. Each operation's frame is then compared bit for bit with an independently built expectation. The request table mixes all three operations with all-ones and all-zeros addresses and byte counts from 0 to 5. This separates a wrong segment order, a wrong field width or a skipped filler run from an off-by-one in the byte counter. Directed cases cover the reserved operation code, a second start during a busy frame, and a program request that carries a non-zero byte count. The duration of the low chip select is also measured to confirm the serial clock period.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_BUFWR = 2'd1,
    OP_PROG  = 2'd2,
    OP_NONE  = 2'd3
  } op_t;

  // Segment order inside a frame; zero-length segments are skipped.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPC  = 3'd1,
    PH_PAGE = 3'd2,
    PH_PRE  = 3'd3,
    PH_COL  = 3'd4,
    PH_POST = 3'd5,
    PH_DATA = 3'd6
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sflash_sck_div.sv
module sflash_sck_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CW'(DIV - 1));
  assign rise = wrap && !sck;
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sflash_rx_shift.sv
module sflash_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (sample) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq
  import sflash_pkg::*;
#(
  parameter int         CLK_DIV   = 2,
  parameter int         OPC_W     = 8,
  parameter int         PAGE_W    = 12,
  parameter int         COL_W     = 10,
  parameter int         LEN_W     = 10,
  parameter int         DATA_W    = 8,
  parameter int         READ_GAP  = 32,
  parameter int         WR_GAP    = 14,
  parameter int         PROG_GAP  = 10,
  parameter logic [7:0] OPC_READ  = 8'hA1,
  parameter logic [7:0] OPC_BUFWR = 8'hB2,
  parameter logic [7:0] OPC_PROG  = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sck,
  output logic              si,
  input  logic              so
);
  localparam int SH_W  = imax(imax(OPC_W, PAGE_W), imax(COL_W, DATA_W));
  localparam int L_MAX = imax(SH_W, imax(READ_GAP, imax(WR_GAP, PROG_GAP)));
  localparam int CNT_W = $clog2(L_MAX + 1);

  // Length in bits of one segment of the frame for a given operation.
  function automatic int unsigned seg_len(input op_t o, input phase_t p, input logic hd);
    case (p)
      PH_OPC:  return OPC_W;
      PH_PAGE: return (o == OP_BUFWR) ? 0 : PAGE_W;
      PH_PRE:  return (o == OP_BUFWR) ? WR_GAP : 0;
      PH_COL:  return (o == OP_PROG) ? 0 : COL_W;
      PH_POST: return (o == OP_READ) ? READ_GAP : ((o == OP_PROG) ? PROG_GAP : 0);
      PH_DATA: return hd ? DATA_W : 0;
      default: return 0;
    endcase
  endfunction

  // First later segment of non-zero length, PH_IDLE when the frame is over.
  function automatic phase_t next_phase(input op_t o, input phase_t p, input logic hd);
    phase_t r = PH_IDLE;
    logic   found = 1'b0;
    for (int k = 1; k < 7; k++) begin
      if (!found && k > int'(p) && seg_len(o, phase_t'(k[2:0]), hd) != 0) begin
        r     = phase_t'(k[2:0]);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] opcode_of(input op_t o);
    case (o)
      OP_READ:  return OPC_READ;
      OP_BUFWR: return OPC_BUFWR;
      default:  return OPC_PROG;
    endcase
  endfunction

  // Segment contents left-aligned so the MSB leaves first; filler is zero.
  function automatic logic [SH_W-1:0] seg_word(input phase_t p, input op_t o,
      input logic [PAGE_W-1:0] pg, input logic [COL_W-1:0] cl, input logic [DATA_W-1:0] wd);
    case (p)
      PH_OPC:  return SH_W'(opcode_of(o)) << (SH_W - OPC_W);
      PH_PAGE: return SH_W'(pg) << (SH_W - PAGE_W);
      PH_COL:  return SH_W'(cl) << (SH_W - COL_W);
      PH_DATA: return (o == OP_BUFWR) ? (SH_W'(wd) << (SH_W - DATA_W)) : '0;
      default: return '0;
    endcase
  endfunction

  phase_t              phase;
  op_t                 op_q;
  logic [PAGE_W-1:0]   page_q;
  logic [COL_W-1:0]    col_q;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    bytes_left;
  logic [CNT_W-1:0]    bitcnt;
  logic [SH_W-1:0]     sh;
  logic                cs_n_q, done_q, rd_valid_q, wr_ready_q;
  logic [DATA_W-1:0]   rd_data_q;
  logic [DATA_W-1:0]   rx_byte;

  // Named internal events
  logic   sck_rise, sck_fall, start_go, seg_end, frame_end, has_data, rx_sample;
  phase_t nxt, load_ph;

  assign busy      = (phase != PH_IDLE);
  assign start_go  = start && !busy && (cmd_op != 2'(OP_NONE));
  assign has_data  = (len_q != '0) && (op_q != OP_PROG);
  assign seg_end   = sck_fall && (bitcnt == CNT_W'(1));
  assign nxt       = next_phase(op_q, phase, has_data);
  assign frame_end = seg_end && ((phase == PH_DATA) ? (bytes_left <= LEN_W'(1))
                                                    : (nxt == PH_IDLE));
  assign load_ph   = (phase == PH_DATA) ? PH_DATA : nxt;
  assign rx_sample = sck_rise && (phase == PH_DATA) && (op_q == OP_READ);

  sflash_sck_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .sck(sck), .rise(sck_rise), .fall(sck_fall)
  );

  sflash_rx_shift #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(rx_sample), .din(so), .q(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      op_q       <= OP_READ;
      page_q     <= '0;
      col_q      <= '0;
      len_q      <= '0;
      bytes_left <= '0;
      bitcnt     <= '0;
      sh         <= '0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      wr_ready_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      wr_ready_q <= 1'b0;
      if (start_go) begin
        op_q       <= op_t'(cmd_op);
        page_q     <= cmd_page;
        col_q      <= cmd_col;
        len_q      <= cmd_len;
        bytes_left <= cmd_len;
        phase      <= PH_OPC;
        bitcnt     <= CNT_W'(OPC_W);
        sh         <= seg_word(PH_OPC, op_t'(cmd_op), cmd_page, cmd_col, wr_data);
        cs_n_q     <= 1'b0;
      end else if (sck_fall) begin
        if (!seg_end) begin
          bitcnt <= bitcnt - CNT_W'(1);
          sh     <= sh << 1;
        end else if (frame_end) begin
          phase  <= PH_IDLE;
          bitcnt <= '0;
          sh     <= '0;
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
        end else begin
          phase  <= load_ph;
          bitcnt <= CNT_W'(seg_len(op_q, load_ph, has_data));
          sh     <= seg_word(load_ph, op_q, page_q, col_q, wr_data);
          if (load_ph == PH_DATA && op_q == OP_BUFWR) wr_ready_q <= 1'b1;
        end
        if (seg_end && phase == PH_DATA) begin
          bytes_left <= bytes_left - LEN_W'(1);
          if (op_q == OP_READ) begin
            rd_data_q  <= rx_byte;
            rd_valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign si       = sh[SH_W-1];
  assign cs_n     = cs_n_q;
  assign done     = done_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign wr_ready = wr_ready_q;

endmodule

// File: rtl/sflash_cmd_seq_chk.sv
module sflash_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sck,
  input logic si,
  input logic rd_valid,
  input logic sck_rise,
  input logic sck_fall,
  input logic start_go,
  input logic frame_end
);
  // R6
  si_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !start_go) |=> $stable(si));
  // R6
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall));
  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  // R7
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  // R7
  frame_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !start_go);
  // R3
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind sflash_cmd_seq sflash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cs_n(cs_n), .sck(sck), .si(si), .rd_valid(rd_valid),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .start_go(start_go),
  .frame_end(frame_end)
);

// File: tb/sflash_cmd_seq_test.sv
module sflash_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam logic [7:0] OPR = 8'hA1, OPW = 8'hB2, OPP = 8'hC3;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] page;
    logic [9:0]  col;
    logic [9:0]  len;
    logic [9:0]  nbits;   // expected frame length in bits
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 12'hABC, 10'h155, 10'd3, 10'd86},
    '{2'd1, 12'h123, 10'h2AA, 10'd2, 10'd48},
    '{2'd2, 12'h5A5, 10'h3FF, 10'd5, 10'd30},
    '{2'd0, 12'hFFF, 10'h3FF, 10'd1, 10'd70},
    '{2'd1, 12'h000, 10'h000, 10'd4, 10'd64},
    '{2'd0, 12'h001, 10'h001, 10'd0, 10'd62}
  };

  logic clk = 0, rst_n = 0, start = 0, so = 0;
  logic [1:0] cmd_op = 0;
  logic [11:0] cmd_page = 0;
  logic [9:0] cmd_col = 0, cmd_len = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, rd_valid, busy, done, cs_n, sck, si;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int nbits = 0, rdn = 0, widx = 0, lowcyc = 0, dones = 0;
  logic [0:199] cap;
  logic [7:0] rdbuf [0:15];
  logic [1:0] cur_op = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_cmd_seq #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_col(cmd_col), .cmd_len(cmd_len),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .cs_n(cs_n),
    .sck(sck), .si(si), .so(so)
  );

  function automatic logic [7:0] rmodel(input logic [11:0] pg, input logic [9:0] cl, input int i);
    return cl[7:0] ^ pg[11:4] ^ (8'h3C + 8'(i) * 8'd29);
  endfunction

  function automatic logic [7:0] wbyte(input int i);
    return 8'h5A + 8'(i) * 8'd71;
  endfunction

  // Flash model: capture si on rising sck, return data on falling sck.
  always @(posedge sck) if (!cs_n) begin cap[nbits] = si; nbits++; end
  always @(negedge sck) if (!cs_n && cur_op == 2'd0 && nbits >= 62) begin
    so = rmodel(cmd_page, cmd_col, (nbits - 62) / 8)[7 - ((nbits - 62) % 8)];
  end

  // Host side monitor, away from the active edge.
  always @(negedge clk) begin
    if (!cs_n) lowcyc++;
    if (done) dones++;
    if (rd_valid && rdn < 16) begin rdbuf[rdn] = rd_data; rdn++; end
    if (wr_ready) begin widx++; wr_data = wbyte(widx); end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    logic [63:0] eh;
    int hl, mis, w;
    nbits = 0; rdn = 0; widx = 0; lowcyc = 0; dones = 0;
    wr_data = wbyte(0); so = 0;
    cmd_op = v.op; cmd_page = v.page; cmd_col = v.col; cmd_len = v.len;
    cur_op = v.op;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_op = 2'd2; cmd_page = 12'h000; start = 1;
      @(negedge clk); start = 0;
      cmd_page = v.page;
    end
    w = 0;
    while (dones == 0 && w < 5000) begin @(negedge clk); w++; end
    chk(w < 5000, "R7 done seen", w, 0);
    @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R7 idle after done", {cs_n, busy}, 2'b10);
    chk(dones == 1, "R7 single done", dones, 1);
    chk(nbits == int'(v.nbits), poke ? "R8 frame length" : "R3/R4/R5 frame length", nbits, v.nbits);
    chk(lowcyc == 2 * DIV * int'(v.nbits), "R6 sck period", lowcyc, 2 * DIV * int'(v.nbits));
    case (v.op)
      2'd0:    begin eh = {OPR, v.page, v.col, 32'h0, 2'b0}; hl = 62; end
      2'd1:    begin eh = {OPW, 14'h0, v.col, 32'h0};       hl = 32; end
      default: begin eh = {OPP, v.page, 10'h0, 34'h0};      hl = 30; end
    endcase
    mis = 0;
    for (int k = 0; k < hl; k++) if (cap[k] !== eh[63-k]) mis++;
    chk(mis == 0, v.op == 0 ? "R3 header" : v.op == 1 ? "R4 header" : "R5 header", mis, 0);
    if (v.op == 2'd1) begin
      mis = 0;
      for (int i = 0; i < int'(v.len); i++)
        for (int b = 0; b < 8; b++)
          if (cap[hl + 8*i + b] !== wbyte(i)[7-b]) mis++;
      chk(mis == 0, "R4 write data bits", mis, 0);
      chk(widx == int'(v.len), "R4 wr_ready count", widx, v.len);
    end else if (v.op == 2'd0) begin
      chk(rdn == int'(v.len), v.len == 0 ? "R9 no read bytes" : "R3 rd_valid count", rdn, v.len);
      mis = 0;
      for (int i = 0; i < int'(v.len); i++) if (rdbuf[i] !== rmodel(v.page, v.col, i)) mis++;
      chk(mis == 0, "R3 read data", mis, 0);
    end else begin
      chk(widx == 0 && rdn == 0, "R5 no data strobes", widx + rdn, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state while reset is held
    chk(cs_n === 1'b1 && sck === 1'b0 && si === 1'b0, "R1 pins in reset", {cs_n, sck, si}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, rd_valid, wr_ready} === 4'b0, "R1 flags after reset",
        {busy, done, rd_valid, wr_ready}, 0);

    for (int n = 0; n < NV; n++) run_vec(VECS[n], 1'b0);

    // R2 reserved operation code is ignored
    nbits = 0;
    cmd_op = 2'd3; @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0 && nbits == 0, "R2 reserved op ignored",
        {cs_n, busy}, 2'b10);

    // R8 start during a busy read frame is ignored
    run_vec('{2'd0, 12'h2C3, 10'h0F0, 10'd1, 10'd70}, 1'b1);

    // R5 program with large length still has no data
    run_vec('{2'd2, 12'hFFF, 10'h000, 10'd9, 10'd30}, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule